// File: doc/BRIEF.md
# Physical Register Reference Tracker

This block decides which physical registers of an out-of-order core are in use, and hands free ones to rename. It keeps a bit matrix. Each column stands for one physical register. Each row stands for one thing that can keep a register alive:

- every issue-queue slot;
- every checkpoint snapshot;
- the live rename map;
- one recovery row per checkpoint region, plus one for the region after the youngest checkpoint.

A register is free exactly when no row has its bit set. A lowest-index priority encoder picks one free register per cycle.

Recovery rows hold destination registers that a rename has overwritten. They let a later misprediction be repaired precisely instead of rolling back to a checkpoint. These rows are optional to correctness, so they are dropped whenever that is convenient. Snapshot rows change only when a checkpoint is taken, retired or squashed.

A recovery row only captures while its region has at least one renamed branch still unexecuted. It is wiped when the last such branch executes, when the core releases it, or when allocation finds nothing free. In that last case the row of the region named as oldest is sacrificed in the same cycle, so the request can still be served.

Top module: `regref_tracker`

## Requirements
- R1: After reset the rename map row holds registers 0 to NARCH-1 and every other row is empty. With default parameters the first allocation returns tag 4.
- R2: A request is granted in the same cycle with the lowest-numbered free register (alloc_vld=1, alloc_tag). From the next cycle that register is held by the rename map row and is not granted again.
- R3: A register set in an issue-queue row by iq_set_en/iq_set_vec (bit n of the slot's slice = register n) stays busy until iq_clr for that slot, after which it can be granted.
- R4: ck_take[c] copies the rename map row into snapshot row c. A register held only by that snapshot stays busy until ck_clr[c].
- R5: When ow_vld removes ow_tag from the map, the tag enters the recovery row of ow_region only if that region has an unexecuted branch. Otherwise it is free from the next cycle.
- R6: Each region counts branches renamed (br_ren) minus executed (br_exe). When the count returns to zero, that region's recovery row is emptied.
- R7: rec_rel[r] empties recovery row r at the next edge, at any time.
- R8: If a request finds no free register, recovery row rec_oldest is ignored for that cycle's choice and emptied at the edge. Other recovery rows are left alone.
- R9: If no register is free even after that, stall=1 and alloc_vld=0, and the rename map gains nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iq_set_en | input | NIQ | Dispatch into issue-queue slot i |
| iq_set_vec | input | NIQ*NPREG | Registers named by each dispatching slot |
| iq_clr | input | NIQ | Slot i executed: drop all its registers |
| ck_take | input | NCKPT | Snapshot the map into checkpoint c |
| ck_clr | input | NCKPT | Checkpoint c retired or squashed |
| ow_vld | input | 1 | A rename overwrote a map entry |
| ow_tag | input | TW | Register that left the map |
| ow_region | input | RW | Region the overwriting rename belongs to |
| br_ren | input | 1 | A branch was renamed |
| br_ren_region | input | RW | Region of the renamed branch |
| br_exe | input | 1 | A branch executed |
| br_exe_region | input | RW | Region of the executed branch |
| rec_rel | input | NCKPT+1 | Release recovery row r |
| rec_oldest | input | RW | Recovery row given up when registers run out |
| alloc_req | input | 1 | Rename asks for one register |
| alloc_vld | output | 1 | Grant this cycle |
| alloc_tag | output | TW | Granted register |
| stall | output | 1 | Request could not be served |

## Verification
The assertions rely on the core using the block sensibly:
- region indices stay below NCKPT+1;
- a region never gets a branch-executed event while its count is zero, and never more renamed branches than its counter holds;
- an overwritten tag is one the map actually holds.

The stimulus is a directed sequence that keeps to these rules. Each overwrite names a mapped register, and every br_exe follows a br_ren on the same region. Allocation results are predicted by hand from the row contents, including the cases where every register is held.

// File: rtl/rrt_pkg.sv
`timescale 1ns/1ps
// Package: default sizes shared by the reference tracker modules.
// Assumes: sizes are small enough for a full bit matrix.
package rrt_pkg;
    localparam int DEF_NPREG = 16;  // physical registers (matrix columns)
    localparam int DEF_NARCH = 4;   // architectural registers mapped at reset
    localparam int DEF_NIQ   = 4;   // issue-queue rows
    localparam int DEF_NCKPT = 2;   // checkpoint rows
    localparam int DEF_CW    = 4;   // per-region branch counter width
endpackage

// File: rtl/rrt_row.sv
`timescale 1ns/1ps
// Module: one row of the reference matrix.
// Holds one bit per physical register. clr_all wipes the row, clr_vec
// clears chosen bits, set_vec sets bits; set wins over both clears.
// Assumes: synchronous active-low reset to RST_VAL.
module rrt_row #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         clr_all,
    output logic [W-1:0] row_q
);
    logic [W-1:0] row_d;

    // Next row value from clears then sets.
    always_comb begin
        row_d = clr_all ? '0 : (row_q & ~clr_vec);
        row_d = row_d | set_vec;
    end

    // Row register.
    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= RST_VAL;
        else        row_q <= row_d;
    end
endmodule

// File: rtl/rrt_prio_enc.sv
`timescale 1ns/1ps
// Module: lowest-index priority encoder over the free vector.
// Assumes: W is at least 2.
module rrt_prio_enc #(
    parameter int W  = 16,
    localparam int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end

    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> req[idx]);  // R2
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> ((req & ((W'(1) << idx) - W'(1))) == '0));  // R2
endmodule

// File: rtl/rrt_branch_track.sv
`timescale 1ns/1ps
// Module: per-region count of renamed but unexecuted branches.
// pend[r] is high while region r has an open branch; drain[r] pulses in
// the cycle its last open branch executes.
// Assumes: no execute event on a region with zero count, and no
// overflow of the CW-bit counter.
module rrt_branch_track #(
    parameter int NREG = 3,
    parameter int CW   = 4,
    localparam int RW  = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_ren,
    input  logic [RW-1:0]   br_ren_region,
    input  logic            br_exe,
    input  logic [RW-1:0]   br_exe_region,
    output logic [NREG-1:0] pend,
    output logic [NREG-1:0] drain
);
    logic [NREG-1:0][CW-1:0] cnt_q;

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic inc, dec;
        assign inc = br_ren && (br_ren_region == RW'(r));
        assign dec = br_exe && (br_exe_region == RW'(r));
        assign pend[r]  = (cnt_q[r] != '0);
        assign drain[r] = dec && !inc && (cnt_q[r] == CW'(1));

        // Open-branch counter of region r.
        always_ff @(posedge clk) begin
            if (!rst_n)          cnt_q[r] <= '0;
            else if (inc && !dec) cnt_q[r] <= cnt_q[r] + CW'(1);
            else if (dec && !inc) cnt_q[r] <= cnt_q[r] - CW'(1);
        end

        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[r] == '0) |-> !(dec && !inc));  // R6
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            (&cnt_q[r]) |-> !(inc && !dec));  // R6
    end

    AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (br_ren -> (32'(br_ren_region) < NREG)) &&
        (br_exe -> (32'(br_exe_region) < NREG)));  // R6
endmodule

// File: rtl/regref_tracker.sv
`timescale 1ns/1ps
// Module: physical register reference tracker (top).
// Bit matrix of issue-queue, checkpoint, rename-map and recovery rows.
// A register is free when its column is all zero. One register is
// granted per cycle, lowest index first. When nothing is free the
// recovery row named by rec_oldest is sacrificed within the same cycle.
// Assumes: ow_tag is held by the map; region indices < NCKPT+1.
module regref_tracker
    import rrt_pkg::*;
#(
    parameter int  NPREG = DEF_NPREG,
    parameter int  NARCH = DEF_NARCH,
    parameter int  NIQ   = DEF_NIQ,
    parameter int  NCKPT = DEF_NCKPT,
    parameter int  CW    = DEF_CW,
    localparam int NREC  = NCKPT + 1,
    localparam int TW    = $clog2(NPREG),
    localparam int RW    = (NREC > 1) ? $clog2(NREC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NIQ-1:0]       iq_set_en,
    input  logic [NIQ*NPREG-1:0] iq_set_vec,
    input  logic [NIQ-1:0]       iq_clr,
    input  logic [NCKPT-1:0]     ck_take,
    input  logic [NCKPT-1:0]     ck_clr,
    input  logic                 ow_vld,
    input  logic [TW-1:0]        ow_tag,
    input  logic [RW-1:0]        ow_region,
    input  logic                 br_ren,
    input  logic [RW-1:0]        br_ren_region,
    input  logic                 br_exe,
    input  logic [RW-1:0]        br_exe_region,
    input  logic [NREC-1:0]      rec_rel,
    input  logic [RW-1:0]        rec_oldest,
    input  logic                 alloc_req,
    output logic                 alloc_vld,
    output logic [TW-1:0]        alloc_tag,
    output logic                 stall
);
    localparam logic [NPREG-1:0] MAP_RST = (NPREG'(1) << NARCH) - NPREG'(1);

    logic [NIQ-1:0][NPREG-1:0]   iq_q;
    logic [NCKPT-1:0][NPREG-1:0] ck_q;
    logic [NREC-1:0][NPREG-1:0]  rec_q;
    logic [NPREG-1:0]            map_q;
    logic [NREC-1:0]             pend, drain;
    logic [NPREG-1:0]            base_or, rec_or_all, rec_or_keep;
    logic [NPREG-1:0]            free_raw, free_eff, enc_req;
    logic [NPREG-1:0]            grant_vec, ow_vec;
    logic                        victim;

    // Open-branch bookkeeping per region.
    rrt_branch_track #(.NREG(NREC), .CW(CW)) i_brt (
        .clk(clk), .rst_n(rst_n),
        .br_ren(br_ren), .br_ren_region(br_ren_region),
        .br_exe(br_exe), .br_exe_region(br_exe_region),
        .pend(pend), .drain(drain)
    );

    // Column reduction: rows that must be honoured vs. recovery rows.
    always_comb begin
        base_or     = map_q;
        rec_or_all  = '0;
        rec_or_keep = '0;
        for (int i = 0; i < NIQ; i++)   base_or = base_or | iq_q[i];
        for (int c = 0; c < NCKPT; c++) base_or = base_or | ck_q[c];
        for (int r = 0; r < NREC; r++) begin
            rec_or_all = rec_or_all | rec_q[r];
            if (RW'(r) != rec_oldest) rec_or_keep = rec_or_keep | rec_q[r];
        end
    end

    // Free-list selection, with victimization when nothing is free.
    always_comb begin
        free_raw = ~(base_or | rec_or_all);
        victim   = alloc_req && (free_raw == '0);
        free_eff = victim ? ~(base_or | rec_or_keep) : free_raw;
        enc_req  = alloc_req ? free_eff : '0;
    end

    rrt_prio_enc #(.W(NPREG)) i_enc (
        .clk(clk), .rst_n(rst_n),
        .req(enc_req), .vld(alloc_vld), .idx(alloc_tag)
    );

    assign stall     = alloc_req && !alloc_vld;
    assign grant_vec = alloc_vld ? (NPREG'(1) << alloc_tag) : '0;
    assign ow_vec    = ow_vld ? (NPREG'(1) << ow_tag) : '0;

    // Rename map row: gains grants, loses overwritten tags.
    rrt_row #(.W(NPREG), .RST_VAL(MAP_RST)) i_map (
        .clk(clk), .rst_n(rst_n),
        .set_vec(grant_vec), .clr_vec(ow_vec), .clr_all(1'b0),
        .row_q(map_q)
    );

    // Issue-queue rows: set at dispatch, wiped at execute.
    for (genvar i = 0; i < NIQ; i++) begin : g_iq
        rrt_row #(.W(NPREG)) i_row (
            .clk(clk), .rst_n(rst_n),
            .set_vec(iq_set_en[i] ? iq_set_vec[i*NPREG +: NPREG] : '0),
            .clr_vec('0), .clr_all(iq_clr[i]),
            .row_q(iq_q[i])
        );
    end

    // Checkpoint rows: replaced on take, wiped on retire or squash.
    for (genvar c = 0; c < NCKPT; c++) begin : g_ck
        rrt_row #(.W(NPREG)) i_row (
            .clk(clk), .rst_n(rst_n),
            .set_vec(ck_take[c] ? map_q : '0),
            .clr_vec('0), .clr_all(ck_take[c] | ck_clr[c]),
            .row_q(ck_q[c])
        );

        AST_CK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(ck_take[c] || ck_clr[c]) |=> $stable(ck_q[c]));  // R4
    end

    // Recovery rows: gated capture, released on any opportunistic event.
    for (genvar r = 0; r < NREC; r++) begin : g_rec
        logic cap, wipe;
        assign cap  = ow_vld && (ow_region == RW'(r)) && pend[r];
        if (r < NCKPT) begin : g_ckc
            assign wipe = drain[r] || rec_rel[r] ||
                          (victim && rec_oldest == RW'(r)) || ck_clr[r];
        end else begin : g_tail
            assign wipe = drain[r] || rec_rel[r] ||
                          (victim && rec_oldest == RW'(r));
        end

        rrt_row #(.W(NPREG)) i_row (
            .clk(clk), .rst_n(rst_n),
            .set_vec(cap ? ow_vec : '0),
            .clr_vec('0), .clr_all(wipe),
            .row_q(rec_q[r])
        );

        AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            !pend[r] |=> ((rec_q[r] & ~$past(rec_q[r])) == '0));  // R5
        AST_DRAIN_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (drain[r] && !(ow_vld && ow_region == RW'(r))) |=> (rec_q[r] == '0));  // R6
        AST_RELEASE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (rec_rel[r] && !(ow_vld && ow_region == RW'(r))) |=> (rec_q[r] == '0));  // R7
        AST_VICTIM_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
            (victim && rec_oldest == RW'(r) && !(ow_vld && ow_region == RW'(r)))
            |=> (rec_q[r] == '0));  // R8
    end

    AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld |=> map_q[$past(alloc_tag)]);  // R2
    AST_GRANT_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_vld |-> !base_or[alloc_tag]);  // R3
    AST_STALL_NO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !ow_vld) |=> $stable(map_q));  // R9
    AST_OW_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        ow_vld |-> (map_q[ow_tag] && (32'(ow_region) < NREC)));  // R5
endmodule

// File: tb/test_regref_tracker.sv
`timescale 1ns/1ps
module test_regref_tracker;
    localparam int NPREG = 16, NIQ = 4, NCKPT = 2, NREC = 3, TW = 4, RW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NIQ-1:0] iq_set_en, iq_clr;
    logic [NIQ*NPREG-1:0] iq_set_vec;
    logic [NCKPT-1:0] ck_take, ck_clr;
    logic ow_vld, br_ren, br_exe, alloc_req;
    logic [TW-1:0] ow_tag;
    logic [RW-1:0] ow_region, br_ren_region, br_exe_region, rec_oldest;
    logic [NREC-1:0] rec_rel;
    logic alloc_vld, stall;
    logic [TW-1:0] alloc_tag;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    typedef struct packed { logic vld; logic [TW-1:0] tag; } exp_t;
    exp_t  exp_q[$];
    string name_q[$];

    always #2 clk = ~clk;

    regref_tracker i_regref_tracker (
        .clk(clk), .rst_n(rst_n),
        .iq_set_en(iq_set_en), .iq_set_vec(iq_set_vec), .iq_clr(iq_clr),
        .ck_take(ck_take), .ck_clr(ck_clr),
        .ow_vld(ow_vld), .ow_tag(ow_tag), .ow_region(ow_region),
        .br_ren(br_ren), .br_ren_region(br_ren_region),
        .br_exe(br_exe), .br_exe_region(br_exe_region),
        .rec_rel(rec_rel), .rec_oldest(rec_oldest),
        .alloc_req(alloc_req), .alloc_vld(alloc_vld),
        .alloc_tag(alloc_tag), .stall(stall)
    );

    task automatic quiet();
        iq_set_en = '0; iq_set_vec = '0; iq_clr = '0; ck_take = '0; ck_clr = '0;
        ow_vld = 0; ow_tag = '0; ow_region = '0; br_ren = 0; br_ren_region = '0;
        br_exe = 0; br_exe_region = '0; rec_rel = '0; rec_oldest = '0; alloc_req = 0;
    endtask

    // Driver: one allocation request, expected result queued.
    task automatic do_alloc(input logic [RW-1:0] old, input logic ev,
                            input int et, input string rq);
        exp_t e;
        @(negedge clk); quiet();
        alloc_req = 1; rec_oldest = old;
        e.vld = ev; e.tag = TW'(et);
        exp_q.push_back(e); name_q.push_back(rq);
    endtask

    task automatic iq_set(input int slot, input logic [NPREG-1:0] v);
        @(negedge clk); quiet(); iq_set_en[slot] = 1; iq_set_vec[slot*NPREG +: NPREG] = v;
    endtask
    task automatic iq_drop(input int slot);
        @(negedge clk); quiet(); iq_clr[slot] = 1;
    endtask
    task automatic overwrite(input int tag, input int reg_n);
        @(negedge clk); quiet(); ow_vld = 1; ow_tag = TW'(tag); ow_region = RW'(reg_n);
    endtask
    task automatic branch_ren(input int reg_n);
        @(negedge clk); quiet(); br_ren = 1; br_ren_region = RW'(reg_n);
    endtask
    task automatic branch_exe(input int reg_n);
        @(negedge clk); quiet(); br_exe = 1; br_exe_region = RW'(reg_n);
    endtask

    // Monitor: compares every request cycle against the scoreboard.
    initial begin
        forever begin
            @(negedge clk); #1;
            if (alloc_req && exp_q.size() > 0) begin
                exp_t e;
                string rq;
                e = exp_q.pop_front(); rq = name_q.pop_front();
                n_run++;
                if (alloc_vld !== e.vld || stall !== !e.vld ||
                    (e.vld && alloc_tag !== e.tag)) begin
                    n_fail++;
                    $display("FAIL %s: vld=%0b tag=%0d stall=%0b, expected vld=%0b tag=%0d stall=%0b",
                             rq, alloc_vld, alloc_tag, stall, e.vld, e.tag, !e.vld);
                end
            end
        end
    end

    initial begin
        quiet();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        n_run++;
        if (alloc_vld !== 0 || stall !== 0) begin
            n_fail++;
            $display("FAIL R1: idle vld=%0b stall=%0b, expected 0 0", alloc_vld, stall);
        end
        do_alloc(0, 1, 4, "R1 first grant");
        do_alloc(0, 1, 5, "R2 next lowest");
        iq_set(0, 16'h00C0);                       // R3: slot 0 holds 6,7
        do_alloc(0, 1, 8, "R3 iq-held skipped");
        iq_drop(0);
        do_alloc(0, 1, 6, "R3 freed after execute");
        @(negedge clk); quiet(); ck_take[0] = 1;   // R4 snapshot
        overwrite(4, 0);                           // region 0 has no branch
        do_alloc(0, 1, 7, "R4 snapshot keeps 4");
        @(negedge clk); quiet(); ck_clr[0] = 1;
        do_alloc(0, 1, 4, "R4 freed on retire");
        overwrite(5, 2);                           // R5 no open branch
        do_alloc(0, 1, 5, "R5 not captured");
        branch_ren(2);
        overwrite(6, 2);
        do_alloc(0, 1, 9, "R5 captured in recovery");
        branch_exe(2);
        do_alloc(0, 1, 6, "R6 drained row freed");
        branch_ren(1);
        overwrite(2, 1);
        do_alloc(0, 1, 10, "R7 held before release");
        @(negedge clk); quiet(); rec_rel[1] = 1;
        do_alloc(0, 1, 2, "R7 released");
        iq_set(1, 16'hF800);                       // 11..15 busy
        overwrite(3, 1);                           // recovery row 1 = {3}
        do_alloc(1, 1, 3, "R8 victim same cycle");
        do_alloc(1, 0, 0, "R9 stall when full");
        iq_drop(1);
        do_alloc(0, 1, 11, "R9 stall took nothing");
        iq_set(2, 16'hF000);
        branch_ren(2);
        overwrite(4, 2);                           // row 2 = {4}
        overwrite(5, 1);                           // row 1 = {5}
        do_alloc(2, 1, 4, "R8 oldest row chosen");
        do_alloc(1, 1, 5, "R8 other row kept");
        do_alloc(0, 0, 0, "R9 stall after victims");
        @(negedge clk); quiet();
        repeat (2) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule